// File: doc/BRIEF.md
# Programmable Video Sync Pulse Generator

This block produces the horizontal and vertical sync outputs of a video timing source running as master. An 8-bit timing word, written and read back over a plain write-enable bus, selects the HSYNC pulse width, the HSYNC position relative to the pixel data, the distance from HSYNC to the vertical event, and a second 2-bit field. That second field has two meanings: in the field-flag mode it moves the field-flag edge by a long fixed offset, and in the vertical-pulse mode it sets the VSYNC width. Every width and offset comes from a short table of non-linear steps, not from a linear count.

An external line counter supplies one-cycle line-start and frame-start strobes. A static mode input picks between a FIELD level output, which toggles once per frame, and an active-low VSYNC pulse. Both are driven on the same pin. A fixed-latency pixel marker shows where pixel data begins, so that moving HSYNC by an odd number of clocks swaps the order of the chroma samples. A new timing word is held in a shadow register and only becomes active at the next line start, so a pulse already in progress keeps its length.

Top module: `sync_pulse_gen`

## Requirements
- R1: The timing word is 8 bits wide. A value written with `cfg_we` reads back on `cfg_rdata` in the following cycle. Reset clears the word to 0.
- R2: A written word governs only pulses triggered at or after the next `line_start` strobe. A pulse already in progress keeps the width it started with.
- R3: `hsync_n` is active low. Bits 1:0 set its width: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 128 clocks. If `line_start` is high in cycle c, `hsync_n` is first low in cycle c+1+s, where s is the shift from R4.
- R4: Bits 7:6 give the shift s (0 to 3 clocks) of HSYNC. `pix_mark` is high for exactly cycle c+3 after a `line_start` in cycle c, whatever the value of s.
- R5: A `frame_start` strobe arms the vertical event. The next HSYNC trigger starts it after a delay D, set by bits 3:2: code 0 gives 0, code 1 gives 4, code 2 gives 8 and code 3 gives 16 clocks. The event becomes visible in cycle c+1+s+D.
- R6: With `mode_vsync`=0, `field_vs` carries a field level that toggles at the vertical event. When bit 4 is 1, the event comes a further OFFSET_CLKS clocks later (default 864, which is 32 µs at 27 MHz). Bit 5 has no effect in this mode.
- R7: With `mode_vsync`=1, `field_vs` is an active-low VSYNC pulse that starts at the vertical event. Bits 5:4 set its width: code 0 gives 1, code 1 gives 4, code 2 gives 16 and code 3 gives 128 clocks. The field level does not change in this mode.
- R8: A `line_start` that takes effect while HSYNC is still low restarts the pulse. HSYNC stays low without a break until the full new width has elapsed.
- R9: After reset, `hsync_n`=1, `pix_mark`=0, and `field_vs` is 0 with `mode_vsync`=0 or 1 with `mode_vsync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_wdata | input | 8 | Timing word write data |
| cfg_rdata | output | 8 | Timing word read back |
| line_start | input | 1 | One-cycle line-start strobe |
| frame_start | input | 1 | One-cycle frame-start strobe |
| mode_vsync | input | 1 | 0: field level output, 1: VSYNC pulse output |
| hsync_n | output | 1 | Active-low horizontal sync |
| field_vs | output | 1 | Field level or active-low VSYNC |
| pix_mark | output | 1 | Pixel-data-start marker |

## Verification
Lines are driven with a range of timing words. Each word uses different width codes, delay codes and shifts, so that a swapped or mis-decoded field shows up as a wrong pulse length or a wrong start cycle. In the field-flag mode, offset bit values of 0 and 1 separate the long-offset path from the base path. In the vertical-pulse mode, the same bits select widths, including a zero delay that must land the event in the HSYNC cycle. One run writes a new word while a 128-clock pulse is in progress, to show that the update is deferred. Another run sends back-to-back line strobes 20 clocks apart, to show that the pulse restarts and does not end early.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

   typedef struct packed {
      logic [1:0] shift;   // HSYNC shift against pixel data
      logic [1:0] vsel;    // offset select (field mode) / VSYNC width
      logic [1:0] dly;     // HSYNC to vertical event delay
      logic [1:0] hw;      // HSYNC width
   } tword_t;

   function automatic int unsigned width_steps(input logic [1:0] code);
      case (code)
         2'd0:    width_steps = 1;
         2'd1:    width_steps = 4;
         2'd2:    width_steps = 16;
         default: width_steps = 128;
      endcase
   endfunction

   function automatic int unsigned delay_steps(input logic [1:0] code);
      case (code)
         2'd0:    delay_steps = 0;
         2'd1:    delay_steps = 4;
         2'd2:    delay_steps = 8;
         default: delay_steps = 16;
      endcase
   endfunction

endpackage

// File: rtl/sync_cfg_reg.sv
module sync_cfg_reg
   import sync_gen_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [7:0]  wdata,
   input  logic        line_start,
   output logic [7:0]  rdata,
   output tword_t      eff
);
   tword_t shadow_q;
   tword_t live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         live_q   <= '0;
      end else begin
         if (we)         shadow_q <= tword_t'(wdata);
         if (line_start) live_q   <= shadow_q;
      end
   end

   // The line that starts in this cycle already sees the pending word.
   assign eff   = line_start ? shadow_q : live_q;
   assign rdata = shadow_q;

   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == $past(wdata)));

   a_r2_deferred: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(live_q));

endmodule

// File: rtl/sync_pulse.sv
module sync_pulse #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [CW-1:0] len,
   output logic          active
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (trig) begin
         active <= 1'b1;
         cnt_q  <= len - CW'(1);
      end else if (active) begin
         if (cnt_q == '0) active <= 1'b0;
         else             cnt_q  <= cnt_q - CW'(1);
      end
   end

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active);

   a_r3_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_q != '0 && !trig) |=> active);

endmodule

// File: rtl/sync_vert_timer.sv
module sync_vert_timer #(
   parameter int OFFSET_CLKS = 864,
   parameter int DW          = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       trig,
   input  logic [1:0] dly_code,
   input  logic       far_sel,
   input  logic       mode_vsync,
   output logic       fire
);
   import sync_gen_pkg::*;

   logic          armed_q;
   logic          run_q;
   logic [DW-1:0] cnt_q;
   logic          arm_now;
   logic          start;
   logic [DW-1:0] total;

   assign arm_now = armed_q | frame_start;
   assign start   = trig & arm_now;
   assign total   = DW'(delay_steps(dly_code))
                  + ((far_sel && !mode_vsync) ? DW'(OFFSET_CLKS) : DW'(0));
   assign fire    = (start && total == '0) || (run_q && !start && cnt_q == DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         run_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (start)            armed_q <= 1'b0;
         else if (frame_start) armed_q <= 1'b1;

         if (start) begin
            run_q <= (total != '0);
            cnt_q <= total;
         end else if (run_q) begin
            if (cnt_q == DW'(1)) run_q <= 1'b0;
            cnt_q <= cnt_q - DW'(1);
         end
      end
   end

   a_r5_arm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !trig) |=> armed_q);

   a_r5_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q > DW'(1)) |=> run_q);

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
   import sync_gen_pkg::*;
#(
   parameter int OFFSET_CLKS = 864,
   parameter int PULSE_CW    = 8,
   parameter int MARK_LAT    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   input  logic       line_start,
   input  logic       frame_start,
   input  logic       mode_vsync,
   output logic       hsync_n,
   output logic       field_vs,
   output logic       pix_mark
);
   localparam int NSHIFT = 4;
   localparam int CHAIN  = (MARK_LAT > NSHIFT - 1) ? MARK_LAT : NSHIFT - 1;
   localparam int DW     = $clog2(delay_steps(2'd3) + OFFSET_CLKS + 1);

   if (PULSE_CW < 8) begin : g_bad_cw
      $error("PULSE_CW must hold a 128-clock width");
   end
   if (OFFSET_CLKS < 1) begin : g_bad_off
      $error("OFFSET_CLKS must be positive");
   end
   if (MARK_LAT < 1) begin : g_bad_lat
      $error("MARK_LAT must be at least 1");
   end

   tword_t     eff;
   logic [CHAIN-1:0] ld_q;
   logic [NSHIFT-1:0] trig_tap;
   logic       hs_trig;
   logic       hs_act;
   logic       vs_act;
   logic       fire;
   logic       field_q;

   sync_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .line_start (line_start),
      .rdata      (cfg_rdata),
      .eff        (eff)
   );

   // Delay line of the line strobe: feeds the HSYNC shift taps and the marker.
   for (genvar i = 0; i < CHAIN; i++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  ld_q[i] <= 1'b0;
         else if (i == 0) ld_q[i] <= line_start;
         else         ld_q[i] <= ld_q[(i == 0) ? 0 : i-1];
      end
   end

   for (genvar t = 0; t < NSHIFT; t++) begin : g_tap
      if (t == 0) begin : g_direct
         assign trig_tap[t] = line_start;
      end else begin : g_delayed
         assign trig_tap[t] = ld_q[t-1];
      end
   end

   assign hs_trig  = trig_tap[eff.shift];
   assign pix_mark = ld_q[MARK_LAT-1];

   sync_pulse #(.CW(PULSE_CW)) u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (hs_trig),
      .len    (PULSE_CW'(width_steps(eff.hw))),
      .active (hs_act)
   );

   sync_vert_timer #(.OFFSET_CLKS(OFFSET_CLKS), .DW(DW)) u_vt (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .trig        (hs_trig),
      .dly_code    (eff.dly),
      .far_sel     (eff.vsel[0]),
      .mode_vsync  (mode_vsync),
      .fire        (fire)
   );

   sync_pulse #(.CW(PULSE_CW)) u_vs (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (fire & mode_vsync),
      .len    (PULSE_CW'(width_steps(eff.vsel))),
      .active (vs_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   field_q <= 1'b0;
      else if (fire && !mode_vsync) field_q <= ~field_q;
   end

   assign hsync_n  = ~hs_act;
   assign field_vs = mode_vsync ? ~vs_act : field_q;

   a_r3_hs_start: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && eff.shift == 2'd0) |=> !hsync_n);

   a_r7_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vsync && $past(mode_vsync)) |-> $stable(field_q));

   a_r4_mark_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_start) |=> !pix_mark);

endmodule

// File: tb/sync_pulse_gen_test.sv
module sync_pulse_gen_test;

   localparam int OFF = 864;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       line_start = 1'b0;
   logic       frame_start = 1'b0;
   logic       mode_vsync = 1'b0;
   logic       hsync_n;
   logic       field_vs;
   logic       pix_mark;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [7:0] word = '0;

   int    hs_st[$];
   int    hs_len[$];
   string hs_tag[$];
   int    vs_st[$];
   int    vs_len[$];
   string vs_tag[$];
   int    fl_at[$];
   string fl_tag[$];
   int    mk_at[$];

   always #2 clk = ~clk;

   sync_pulse_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .line_start(line_start), .frame_start(frame_start),
      .mode_vsync(mode_vsync), .hsync_n(hsync_n), .field_vs(field_vs),
      .pix_mark(pix_mark)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int wsteps(input logic [1:0] c);
      return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 16 : 128;
   endfunction
   function automatic int dsteps(input logic [1:0] c);
      return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic write_word(input logic [7:0] v);
      cfg_we = 1'b1;
      cfg_wdata = v;
      tick();
      cfg_we = 1'b0;
      word = v;
      check(cfg_rdata == v, "R1 readback", int'(cfg_rdata), int'(v));
   endtask

   // Pulse a line (optionally after a frame strobe) and queue what must follow.
   task automatic run_line(input bit frame, input string tag, input int wait_n);
      int c, s, d;
      if (frame) begin
         frame_start = 1'b1;
         tick();
         frame_start = 1'b0;
      end
      c = cyc;
      s = int'(word[7:6]);
      d = dsteps(word[3:2]);
      line_start = 1'b1;
      hs_st.push_back(c + 1 + s);
      hs_len.push_back(wsteps(word[1:0]));
      hs_tag.push_back({tag, " R3 R4"});
      mk_at.push_back(c + 3);
      if (frame) begin
         if (mode_vsync) begin
            vs_st.push_back(c + 1 + s + d);
            vs_len.push_back(wsteps(word[5:4]));
            vs_tag.push_back({tag, " R5 R7"});
         end else begin
            fl_at.push_back(c + 1 + s + d + (word[4] ? OFF : 0));
            fl_tag.push_back({tag, " R5 R6"});
         end
      end
      tick();
      line_start = 1'b0;
      repeat (wait_n) tick();
   endtask

   // Scoreboard monitor
   logic p_hs = 1'b1, p_fv = 1'b0, p_mode = 1'b0;
   int   hs_t0 = 0, vs_t0 = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (p_hs && !hsync_n) hs_t0 = cyc;
         if (!p_hs && hsync_n) begin
            if (hs_st.size() == 0) check(1'b0, "R3 unexpected HSYNC", cyc, -1);
            else begin
               string t;
               int st, ln;
               st = hs_st.pop_front(); ln = hs_len.pop_front(); t = hs_tag.pop_front();
               check(hs_t0 == st, {t, " hs start"}, hs_t0, st);
               check(cyc - hs_t0 == ln, {t, " hs width"}, cyc - hs_t0, ln);
            end
         end
         if (mode_vsync && p_mode) begin
            if (p_fv && !field_vs) vs_t0 = cyc;
            if (!p_fv && field_vs) begin
               if (vs_st.size() == 0) check(1'b0, "R7 unexpected VSYNC", cyc, -1);
               else begin
                  string t;
                  int st, ln;
                  st = vs_st.pop_front(); ln = vs_len.pop_front(); t = vs_tag.pop_front();
                  check(vs_t0 == st, {t, " vs start"}, vs_t0, st);
                  check(cyc - vs_t0 == ln, {t, " vs width"}, cyc - vs_t0, ln);
               end
            end
         end
         if (!mode_vsync && !p_mode && field_vs != p_fv) begin
            if (fl_at.size() == 0) check(1'b0, "R6 unexpected field toggle", cyc, -1);
            else begin
               string t;
               int at;
               at = fl_at.pop_front(); t = fl_tag.pop_front();
               check(cyc == at, {t, " field toggle"}, cyc, at);
            end
         end
         if (pix_mark) begin
            if (mk_at.size() == 0) check(1'b0, "R4 unexpected marker", cyc, -1);
            else begin
               int at;
               at = mk_at.pop_front();
               check(cyc == at, "R4 marker", cyc, at);
            end
         end
         p_hs = hsync_n;
         p_fv = field_vs;
         p_mode = mode_vsync;
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : driver
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R9 reset state
      check(hsync_n == 1'b1, "R9 hsync_n", int'(hsync_n), 1);
      check(field_vs == 1'b0, "R9 field", int'(field_vs), 0);
      check(pix_mark == 1'b0, "R9 marker", int'(pix_mark), 0);
      check(cfg_rdata == 8'h00, "R1 reset value", int'(cfg_rdata), 0);
      mode_vsync = 1'b1;
      tick();
      check(field_vs == 1'b1, "R9 vsync idle", int'(field_vs), 1);
      mode_vsync = 1'b0;
      repeat (2) tick();

      // Field mode
      run_line(1'b1, "mode1 w1 d0", 200);
      write_word(8'h05);
      run_line(1'b1, "mode1 w4 d4", 200);
      write_word(8'h1A);                    // w16 d8 far offset
      run_line(1'b1, "R6 far", 1100);
      write_word(8'h2A);                    // bit5 only: no far offset
      run_line(1'b1, "R6 bit5 ignored", 200);
      write_word(8'hC3);                    // shift 3, w128, no frame
      run_line(1'b0, "shift3", 300);

      // VSYNC mode
      mode_vsync = 1'b1;
      repeat (3) tick();
      write_word(8'h2E);
      run_line(1'b1, "mode2 vw16 d16", 300);
      write_word(8'h74);
      run_line(1'b1, "mode2 vw128 d4 s1", 300);
      write_word(8'h40);
      run_line(1'b1, "mode2 d0 s1", 100);
      mode_vsync = 1'b0;
      repeat (3) tick();

      // R2: write during a 128 pulse, effect only at next line
      write_word(8'h03);
      run_line(1'b0, "R2 before", 0);
      write_word(8'h00);
      repeat (200) tick();
      run_line(1'b0, "R2 after", 50);

      // R8: restart 20 clocks into a 128 pulse
      write_word(8'h03);
      begin
         int c1;
         c1 = cyc;
         line_start = 1'b1;
         hs_st.push_back(c1 + 1);
         hs_len.push_back(20 + 128);
         hs_tag.push_back("R8 restart");
         mk_at.push_back(c1 + 3);
         mk_at.push_back(c1 + 23);
         tick();
         line_start = 1'b0;
         repeat (19) tick();
         line_start = 1'b1;
         tick();
         line_start = 1'b0;
         repeat (300) tick();
      end

      check(hs_st.size() == 0, "R3 pending HSYNC", hs_st.size(), 0);
      check(vs_st.size() == 0, "R7 pending VSYNC", vs_st.size(), 0);
      check(fl_at.size() == 0, "R6 pending field", fl_at.size(), 0);
      check(mk_at.size() == 0, "R4 pending marker", mk_at.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule